// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the synchronous control core of a LIN bus node's power and mode logic. It watches a supply-good flag, the enable and transmit-data pins from the host microcontroller, a filtered sample of the bus level and a regulator undervoltage flag. From these it decides when the local regulator runs, when the host is held in reset, whether the transmitter may pull the bus dominant, what the receive-data pin shows and whether slave termination is connected.

The host moves the node between its modes with two pins. Raising enable from fail-safe or silent mode enters normal mode. A falling enable edge in normal mode opens a short mode-select window. If transmit data is low for the whole window, the node goes to sleep. Otherwise it goes to silent mode. A dominant level that stays on the bus for a minimum time wakes the node from silent or sleep mode back into fail-safe mode. A guard timer stops a stuck-low transmit pin from holding the bus dominant. Every time interval is a clock-cycle parameter, and the defaults assume a 1 MHz clock.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rstN is low, and while the supply is not good, all five outputs are 0. With supplyOk high after reset, the controller enters fail-safe mode. In fail-safe mode regOn=1, termOn=1, txDrive=0 and rxdOut=1, unless a wake-up caused the entry (see R10).
- R2: If supplyOk is sampled low in any state, then from the next cycle regOn, resetN, rxdOut, txDrive and termOn are all 0.
- R3: resetN is 0 in any cycle where the regulator is off or vccUnder is high. It returns to 1 exactly RST_CYC cycles after the last cycle in which either condition held.
- R4: When enPin is high in fail-safe or silent mode, the controller enters normal mode. In normal mode txDrive = NOT txdPin, subject to R11 and R12, and rxdOut = NOT busDom (busDom=1 means the bus is dominant).
- R5: A falling edge on enPin in normal mode opens a mode-select window of SEL_WIN_CYC cycles. From the next cycle txDrive is 0 and rxdOut is 1.
- R6: If txdPin is high in any sample of the window, the node enters silent mode. In silent mode regOn=1, termOn=1, txDrive=0 and rxdOut=1 whatever the bus level.
- R7: If txdPin is low in the edge sample and in every window sample, the node enters sleep mode. In sleep mode regOn, resetN, rxdOut, txDrive and termOn are all 0.
- R8: In sleep mode enPin has no effect. Only a bus wake-up or supply loss leaves sleep mode.
- R9: In silent or sleep mode, busDom held high for WAKE_CYC consecutive cycles moves the node to fail-safe mode. A shorter dominant pulse restarts the filter from zero.
- R10: After fail-safe mode has been entered by a bus wake-up, rxdOut stays 0 until the node leaves fail-safe mode.
- R11: In normal mode txDrive is released after DOM_TO_CYC consecutive cycles with txdPin low.
- R12: After a dominant timeout, txDrive stays 0 while txdPin stays low. It is re-armed once txdPin has been sampled high.
- R13: With the regulator on, vccUnder forces resetN to 0 in the same cycle. From the next cycle the node is held in fail-safe mode, with txDrive at 0, for as long as the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Battery supply above the operating threshold |
| enPin | input | 1 | Enable pin from the host |
| txdPin | input | 1 | Transmit data pin; 0 requests a dominant bus |
| busDom | input | 1 | Filtered bus sample; 1 means dominant |
| vccUnder | input | 1 | Regulator output undervoltage flag |
| regOn | output | 1 | Regulator enable |
| resetN | output | 1 | Active-low reset to the host |
| rxdOut | output | 1 | Receive data pin level |
| txDrive | output | 1 | Bus driver pulls dominant |
| termOn | output | 1 | Slave termination connected |

## Verification
The checker asserts the following on every cycle:
- supply loss switches everything off on the next cycle;
- reset is held while the regulator is off;
- the driver is active only with transmit data low;
- an enable fall releases the driver on the next cycle;
- an undervoltage keeps the driver off;
- no run of driver-active cycles exceeds the dominant timeout.

Some behaviour can only be shown by the bench's scenarios, because it depends on what happened earlier:
- the sleep/silent choice, which depends on transmit data across the whole window;
- the wake filter restarting after a short pulse;
- the wake indication on receive data;
- the driver staying off after a timeout until transmit data goes high;
- enable being ignored in sleep;
- the exact reset release time.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    ST_UNPWR,
    ST_FAILSAFE,
    ST_NORMAL,
    ST_SELECT,
    ST_SILENT,
    ST_SLEEP
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selStart;  // enable fall seen in normal mode
    logic selRun;    // mode-select window in progress
    logic txArm;     // transmitter may drive
    logic wakeArm;   // wake filter active
    logic rstHold;   // keep host reset asserted
  } ctrl_strb_t;

  // status from datapath back to control
  typedef struct packed {
    logic selDone;   // last cycle of the window
    logic winLow;    // transmit data low in every window sample
    logic wakeHit;   // dominant held for the filter time
  } dp_stat_t;

endpackage

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enPin,
  input  logic       busDom,
  input  logic       vccUnder,
  input  dp_stat_t   stat,
  output ctrl_strb_t strb,
  output logic       regOn,
  output logic       rxdOut,
  output logic       termOn
);

  mode_e state, nxt;
  logic  enPrev;
  logic  enFall;
  logic  wakeFlag;
  logic  regOnNow;

  assign enFall   = enPrev & ~enPin;
  assign regOnNow = (state != ST_UNPWR) && (state != ST_SLEEP);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_UNPWR:    nxt = ST_FAILSAFE;
      ST_FAILSAFE: if (enPin) nxt = ST_NORMAL;
      ST_NORMAL:   if (enFall) nxt = ST_SELECT;
      ST_SELECT:   if (stat.selDone) nxt = stat.winLow ? ST_SLEEP : ST_SILENT;
      ST_SILENT: begin
        if (enPin)             nxt = ST_NORMAL;
        else if (stat.wakeHit) nxt = ST_FAILSAFE;
      end
      ST_SLEEP:    if (stat.wakeHit) nxt = ST_FAILSAFE;
      default:     nxt = ST_UNPWR;
    endcase
    if (regOnNow && vccUnder) nxt = ST_FAILSAFE;
    if (!supplyOk)            nxt = ST_UNPWR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_UNPWR;
      enPrev   <= 1'b0;
      wakeFlag <= 1'b0;
    end else begin
      state    <= nxt;
      enPrev   <= enPin;
      wakeFlag <= (nxt == ST_FAILSAFE) &&
                  (wakeFlag ||
                   (((state == ST_SILENT) || (state == ST_SLEEP)) && stat.wakeHit));
    end
  end

  always_comb begin
    unique case (state)
      ST_NORMAL:   rxdOut = ~busDom;
      ST_FAILSAFE: rxdOut = ~wakeFlag;
      ST_SELECT,
      ST_SILENT:   rxdOut = 1'b1;
      default:     rxdOut = 1'b0;
    endcase
  end

  assign regOn  = regOnNow;
  assign termOn = regOnNow;

  assign strb.selStart = (state == ST_NORMAL) && enFall;
  assign strb.selRun   = (state == ST_SELECT);
  assign strb.txArm    = (state == ST_NORMAL);
  assign strb.wakeArm  = (state == ST_SILENT) || (state == ST_SLEEP);
  assign strb.rstHold  = ~regOnNow | vccUnder;

endmodule

// File: rtl/lin_mode_dp.sv
module lin_mode_dp
  import lin_mode_pkg::*;
#(
  parameter int SEL_WIN_CYC = 3,
  parameter int DOM_TO_CYC  = 6000,
  parameter int WAKE_CYC    = 100,
  parameter int RST_CYC     = 4000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_strb_t strb,
  input  logic       txdPin,
  input  logic       busDom,
  output dp_stat_t   stat,
  output logic       txDrive,
  output logic       resetN
);

  localparam int SW = $clog2(SEL_WIN_CYC + 1);
  localparam int DW = $clog2(DOM_TO_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int RW = $clog2(RST_CYC + 1);

  localparam logic [SW-1:0] SEL_LOAD  = SW'(SEL_WIN_CYC);
  localparam logic [SW-1:0] SEL_ONE   = SW'(1);
  localparam logic [DW-1:0] DOM_LAST  = DW'(DOM_TO_CYC - 1);
  localparam logic [WW-1:0] WAKE_FULL = WW'(WAKE_CYC);
  localparam logic [RW-1:0] RST_LOAD  = RW'(RST_CYC);

  // mode-select window
  logic [SW-1:0] selCnt;
  logic          lowAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selCnt <= '0;
      lowAll <= 1'b0;
    end else if (strb.selStart) begin
      selCnt <= SEL_LOAD;
      lowAll <= ~txdPin;
    end else if (strb.selRun) begin
      if (selCnt != '0) selCnt <= selCnt - 1'b1;
      lowAll <= lowAll & ~txdPin;
    end
  end

  assign stat.selDone = strb.selRun && (selCnt == SEL_ONE);
  assign stat.winLow  = lowAll & ~txdPin;

  // dominant-timeout guard
  logic [DW-1:0] domCnt;
  logic          domLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domCnt  <= '0;
      domLock <= 1'b0;
    end else if (txdPin) begin
      domCnt  <= '0;
      domLock <= 1'b0;
    end else if (!strb.txArm) begin
      domCnt  <= '0;
    end else if (!domLock) begin
      if (domCnt == DOM_LAST) begin
        domLock <= 1'b1;
        domCnt  <= '0;
      end else begin
        domCnt  <= domCnt + 1'b1;
      end
    end
  end

  assign txDrive = strb.txArm & ~txdPin & ~domLock;

  // bus wake-up filter, saturating
  logic [WW-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         wakeCnt <= '0;
    else if (!strb.wakeArm || !busDom) wakeCnt <= '0;
    else if (wakeCnt != WAKE_FULL)     wakeCnt <= wakeCnt + 1'b1;
  end

  assign stat.wakeHit = (wakeCnt == WAKE_FULL);

  // host reset stretch
  logic [RW-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rstCnt <= RST_LOAD;
    else if (strb.rstHold) rstCnt <= RST_LOAD;
    else if (rstCnt != '0) rstCnt <= rstCnt - 1'b1;
  end

  assign resetN = ~strb.rstHold && (rstCnt == '0);

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int SEL_WIN_CYC = 3,
  parameter int DOM_TO_CYC  = 6000,
  parameter int WAKE_CYC    = 100,
  parameter int RST_CYC     = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic enPin,
  input  logic txdPin,
  input  logic busDom,
  input  logic vccUnder,
  output logic regOn,
  output logic resetN,
  output logic rxdOut,
  output logic txDrive,
  output logic termOn
);

  ctrl_strb_t strb;
  dp_stat_t   stat;

  lin_mode_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .enPin    (enPin),
    .busDom   (busDom),
    .vccUnder (vccUnder),
    .stat     (stat),
    .strb     (strb),
    .regOn    (regOn),
    .rxdOut   (rxdOut),
    .termOn   (termOn)
  );

  lin_mode_dp #(
    .SEL_WIN_CYC (SEL_WIN_CYC),
    .DOM_TO_CYC  (DOM_TO_CYC),
    .WAKE_CYC    (WAKE_CYC),
    .RST_CYC     (RST_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txdPin  (txdPin),
    .busDom  (busDom),
    .stat    (stat),
    .txDrive (txDrive),
    .resetN  (resetN)
  );

endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk #(
  parameter int DOM_TO_CYC = 6000
) (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic enPin,
  input logic txdPin,
  input logic vccUnder,
  input logic regOn,
  input logic resetN,
  input logic rxdOut,
  input logic txDrive,
  input logic termOn
);

  localparam int CW = $clog2(DOM_TO_CYC + 2);
  localparam logic [CW-1:0] RUN_CAP = CW'(DOM_TO_CYC + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(DOM_TO_CYC);

  logic [CW-1:0] domRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             domRun <= '0;
    else if (!txDrive)                     domRun <= '0;
    else if (domRun != RUN_CAP)            domRun <= domRun + 1'b1;
  end

  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!regOn && !resetN && !rxdOut && !txDrive && !termOn)); // R2

  AST_RESET_WHILE_REG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !regOn |-> !resetN); // R3

  AST_DRIVE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    txDrive |-> (!txdPin && regOn && termOn)); // R4

  AST_EN_FALL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enPin) |=> !txDrive); // R5

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !regOn) |-> (!rxdOut && !termOn)); // R7

  AST_DOM_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    txDrive |-> (domRun < RUN_MAX)); // R11

  AST_UV_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    vccUnder |=> !txDrive); // R13

endmodule

bind lin_mode_ctrl lin_mode_chk #(.DOM_TO_CYC(DOM_TO_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .supplyOk (supplyOk),
  .enPin    (enPin),
  .txdPin   (txdPin),
  .vccUnder (vccUnder),
  .regOn    (regOn),
  .resetN   (resetN),
  .rxdOut   (rxdOut),
  .txDrive  (txDrive),
  .termOn   (termOn)
);

// File: tb/sim_lin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lin_mode_ctrl;

  localparam int SEL_WIN_CYC = 3;
  localparam int DOM_TO_CYC  = 6000;
  localparam int WAKE_CYC    = 100;
  localparam int RST_CYC     = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic enPin = 1'b0;
  logic txdPin = 1'b1;
  logic busDom = 1'b0;
  logic vccUnder = 1'b0;
  logic regOn, resetN, rxdOut, txDrive, termOn;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lin_mode_ctrl #(
    .SEL_WIN_CYC (SEL_WIN_CYC),
    .DOM_TO_CYC  (DOM_TO_CYC),
    .WAKE_CYC    (WAKE_CYC),
    .RST_CYC     (RST_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enPin(enPin),
    .txdPin(txdPin), .busDom(busDom), .vccUnder(vccUnder),
    .regOn(regOn), .resetN(resetN), .rxdOut(rxdOut),
    .txDrive(txDrive), .termOn(termOn)
  );

  // expected output vector order: {regOn, resetN, rxdOut, txDrive, termOn}
  typedef struct {
    string      req;
    logic [4:0] exp;
  } item_t;

  item_t sbQ[$];

  // monitor: pops each expected item one time unit after it is pushed
  initial begin
    forever begin
      wait (sbQ.size() > 0);
      #1;
      begin
        item_t it;
        logic [4:0] got;
        it  = sbQ.pop_front();
        got = {regOn, resetN, rxdOut, txDrive, termOn};
        nTests++;
        if (got !== it.exp) begin
          nFails++;
          $display("FAIL %s: got %b expected %b", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [4:0] exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    sbQ.push_back(it);
    #2;
  endtask

  initial begin
    tick(2);
    expect_out("R1 held in reset", 5'b00000);
    supplyOk = 1'b1;
    tick(1);
    expect_out("R1 reset with supply", 5'b00000);
    rstN = 1'b1;
    tick(2);
    expect_out("R1 fail-safe after power-up", 5'b10101);
    tick(RST_CYC / 2);
    expect_out("R3 reset still stretched", 5'b10101);
    tick(RST_CYC);
    expect_out("R3 reset released", 5'b11101);

    enPin = 1'b1;
    tick(2);
    expect_out("R4 normal, bus recessive", 5'b11101);
    busDom = 1'b1;
    expect_out("R4 rxd follows dominant bus", 5'b11001);
    txdPin = 1'b0;
    expect_out("R4 txd low drives dominant", 5'b11011);

    tick(DOM_TO_CYC - 10);
    expect_out("R11 still driving before timeout", 5'b11011);
    tick(20);
    expect_out("R11 driver released after timeout", 5'b11001);
    tick(5);
    expect_out("R12 stays released while txd low", 5'b11001);
    txdPin = 1'b1;
    tick(1);
    txdPin = 1'b0;
    expect_out("R12 re-armed after txd high", 5'b11011);
    txdPin = 1'b1;
    busDom = 1'b0;
    tick(1);

    enPin = 1'b0;
    tick(1);
    expect_out("R5 window, driver off", 5'b11101);
    tick(10);
    busDom = 1'b1;
    expect_out("R6 silent rxd held high", 5'b11101);
    tick(WAKE_CYC - 5);
    busDom = 1'b0;
    tick(3);
    expect_out("R9 short pulse no wake", 5'b11101);
    busDom = 1'b1;
    tick(WAKE_CYC + 5);
    expect_out("R9 wake from silent", 5'b11001);
    busDom = 1'b0;
    tick(2);
    expect_out("R10 wake flag on rxd", 5'b11001);

    enPin = 1'b1;
    tick(2);
    expect_out("R4 normal from fail-safe", 5'b11101);

    txdPin = 1'b0;
    enPin  = 1'b0;
    tick(1);
    expect_out("R5 window with txd low", 5'b11101);
    tick(10);
    expect_out("R7 sleep", 5'b00000);
    enPin = 1'b1;
    tick(5);
    expect_out("R8 enable ignored in sleep", 5'b00000);
    enPin = 1'b0;
    tick(1);

    busDom = 1'b1;
    tick(WAKE_CYC + 5);
    expect_out("R9 wake from sleep", 5'b10001);
    busDom = 1'b0;
    tick(RST_CYC + 5);
    expect_out("R3 reset released after wake", 5'b11001);

    txdPin = 1'b1;
    enPin  = 1'b1;
    tick(2);
    expect_out("R4 normal again", 5'b11101);
    txdPin = 1'b0;
    enPin  = 1'b0;
    tick(1);
    txdPin = 1'b1;
    tick(10);
    expect_out("R6 txd high inside window gives silent", 5'b11101);

    enPin = 1'b1;
    tick(2);
    expect_out("R4 normal from silent", 5'b11101);
    vccUnder = 1'b1;
    expect_out("R13 undervoltage resets at once", 5'b10101);
    tick(2);
    txdPin = 1'b0;
    expect_out("R13 driver held off", 5'b10101);
    vccUnder = 1'b0;
    txdPin   = 1'b1;
    tick(2);
    expect_out("R3 reset stretched after undervoltage", 5'b10101);
    tick(RST_CYC + 5);
    expect_out("R3 reset released after undervoltage", 5'b11101);

    supplyOk = 1'b0;
    tick(1);
    expect_out("R2 supply loss", 5'b00000);
    tick(2);
    expect_out("R2 stays unpowered", 5'b00000);
    enPin    = 1'b0;
    supplyOk = 1'b1;
    tick(3);
    expect_out("R1 fail-safe after supply return", 5'b10101);

    tick(2);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule